// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block is the read-side front end of a memory with a 32-bit data path, addressed in 32-bit double words. It serves two kinds of read. In asynchronous mode the word at the presented address comes out one clock later. In clocked burst mode a start address is captured on an address-valid strobe. After a programmable number of clocks, the block returns one word per clock from a linear address sequence. That sequence either wraps inside an aligned block of 2, 4 or 8 words or runs on without limit.

A 16-bit configuration register holds the mode, the burst length code and the initial latency. It changes only when a dedicated set-configuration command is issued on the command port. During a wrapping burst, an active-low indicator output marks the final word. Dropping chip select abandons any transfer and disables the data output in the same cycle. The storage behind the sequencer is a read-only lookup with one registered read stage, filled with a known pattern so that every returned word can be predicted.

Top module: `burst_read_seq`

## Requirements
- R1: The word stored at double-word address a is {~z, z}, where z is a zero-extended to 16 bits. The lower half is z and the upper half is its bitwise complement.
- R2: When configuration bit 15 is 0 (asynchronous) and chip_sel is high, the address sampled at a clock edge is returned on dq_data after that edge with dq_oe high, and ind_n stays high.
- R3: The configuration register loads cmd_arg only at an edge where cmd_valid is high and cmd_op equals 8'hD0. Any other opcode, or that opcode without cmd_valid, leaves it unchanged.
- R4: While reset is applied, dq_oe is low and ind_n is high. After reset the configuration holds 16'h3C03: asynchronous, latency 15, 8-word wrap.
- R5: When configuration bit 15 is 1, an edge with chip_sel and addr_valid high latches addr as the start. The first word appears after the L-th following edge, where L is configuration bits 13:10 and values below 2 count as 2. dq_oe stays low while the block waits.
- R6: Configuration bits 2:0 select the burst length: 3'b001 gives 2 words, 3'b010 gives 4 and 3'b011 gives 8. Words then follow one per clock with no gaps.
- R7: A wrapping burst of N words starting at s returns, for k = 0..N-1, the address whose upper bits equal those of s and whose low log2(N) bits are (s+k) mod N.
- R8: ind_n is low exactly while the last word of a wrapping burst is on dq_data. At the edge after that word, dq_oe falls.
- R9: Any other length code gives a continuous burst s, s+1, s+2, … modulo the array size. In such a burst ind_n stays high.
- R10: With chip_sel low, dq_oe is low in that same cycle without waiting for a clock edge. The burst is dropped, and raising chip_sel again does not resume it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode; 8'hD0 writes the configuration |
| cmd_arg | input | 16 | Configuration value carried by the command |
| chip_sel | input | 1 | Active-high chip select; low aborts and disables output |
| addr_valid | input | 1 | Start-address strobe for burst mode |
| addr | input | AW (8) | Double-word address |
| dq_data | output | 32 | Read data |
| dq_oe | output | 1 | Output driver enable; data is valid when high |
| ind_n | output | 1 | Active-low last-word indicator |

## Verification
The assertions assume that addr_valid is only meaningful while chip_sel is high. They also assume that the mode bit does not change while a burst is in flight, because the sequencer reads the mode live but latches latency and length at the strobe. The stimulus therefore writes the configuration only while the sequencer is idle. It holds chip_sel high through every burst except the one that deliberately tests an abort, and it raises addr_valid for a single cycle per burst.

// File: rtl/brs_pkg.sv
package brs_pkg;

  localparam int unsigned CFG_W       = 16;
  localparam int unsigned OP_W        = 8;
  localparam int unsigned LAT_W       = 4;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned SYNC_BIT    = 15;
  localparam int unsigned LAT_LSB     = 10;
  localparam logic [CFG_W-1:0] CFG_RST = 16'h3C03;
  localparam logic [OP_W-1:0]  OP_SETCFG = 8'hD0;
  localparam logic [LAT_W-1:0] LAT_MIN   = 4'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER
  } brs_state_e;

  // log2 of the wrap length; 0 means continuous linear burst
  function automatic logic [1:0] wrap_bits(input logic [2:0] code);
    case (code)
      3'b001:  return 2'd1;
      3'b010:  return 2'd2;
      3'b011:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] word_of(input logic [15:0] a);
    return {~a, a};
  endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [OP_W-1:0]  cmd_op,
  input  logic [CFG_W-1:0] cmd_arg,
  output logic [CFG_W-1:0] cfg_q
);

  logic load;
  assign load = cmd_valid && (cmd_op == OP_SETCFG);

  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= CFG_RST;
    else if (load) cfg_q <= cmd_arg;
  end

  assert_cfg_cmd_only_R3: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && (cmd_op == OP_SETCFG)) |=> $stable(cfg_q));

endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen #(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] step,
  input  logic [1:0]    wbits,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] sum;
  logic [AW-1:0] mask;

  always_comb begin
    sum  = start + step;
    mask = (AW'(1) << wbits) - AW'(1);
    if (wbits == 2'd0) addr = sum;
    else               addr = (start & ~mask) | (sum & mask);
  end

endmodule

// File: rtl/brs_array.sv
module brs_array
  import brs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = word_of(16'(i));
  end

  always_ff @(posedge clk) rdata <= rom[raddr];

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [CFG_W-1:0]  cmd_arg,
  input  logic              chip_sel,
  input  logic              addr_valid,
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] dq_data,
  output logic              dq_oe,
  output logic              ind_n
);

  logic [CFG_W-1:0] cfg_q;
  logic             sync_mode;
  logic [LAT_W-1:0] lat_field, eff_lat;
  logic             cfg_unused;

  brs_state_e       st_q;
  logic [LAT_W-1:0] cnt_q, lat_q;
  logic [AW-1:0]    start_q, k_q, blk, gen_addr, rd_addr;
  logic [1:0]       wb_q;
  logic             vld_q, last_q;

  brs_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cfg_q(cfg_q)
  );

  assign sync_mode  = cfg_q[SYNC_BIT];
  assign lat_field  = cfg_q[LAT_LSB +: LAT_W];
  assign eff_lat    = (lat_field < LAT_MIN) ? LAT_MIN : lat_field;
  assign cfg_unused = ^{cfg_q[14], cfg_q[9:3]};
  assign blk        = AW'(1) << wb_q;

  brs_addr_gen #(.AW(AW)) u_agen (
    .start(start_q), .step(k_q), .wbits(wb_q), .addr(gen_addr)
  );

  assign rd_addr = sync_mode ? gen_addr : addr;

  brs_array #(.AW(AW)) u_arr (
    .clk(clk), .raddr(rd_addr), .rdata(dq_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      vld_q   <= 1'b0;
      last_q  <= 1'b0;
      cnt_q   <= '0;
      lat_q   <= LAT_MIN;
      k_q     <= '0;
      start_q <= '0;
      wb_q    <= '0;
    end else begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      if (!chip_sel) begin
        st_q <= ST_IDLE;
      end else if (!sync_mode) begin
        st_q  <= ST_IDLE;
        vld_q <= 1'b1;
      end else if (addr_valid) begin
        start_q <= addr;
        k_q     <= '0;
        cnt_q   <= LAT_W'(1);
        lat_q   <= eff_lat;
        wb_q    <= wrap_bits(cfg_q[2:0]);
        st_q    <= ST_WAIT;
      end else begin
        case (st_q)
          ST_WAIT: begin
            if (cnt_q == lat_q) begin
              vld_q <= 1'b1;
              k_q   <= AW'(1);
              st_q  <= ST_XFER;
            end else begin
              cnt_q <= cnt_q + LAT_W'(1);
            end
          end
          ST_XFER: begin
            if (wb_q != 2'd0 && k_q == blk) begin
              st_q <= ST_IDLE;
            end else begin
              vld_q  <= 1'b1;
              last_q <= (wb_q != 2'd0) && (k_q == blk - AW'(1));
              k_q    <= k_q + AW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dq_oe = vld_q & chip_sel;
  assign ind_n = ~(last_q & chip_sel);

  assert_wait_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> !vld_q);

  assert_wait_count_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> (cnt_q != '0 && cnt_q <= lat_q));

  assert_wrap_index_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER && wb_q != 2'd0) |-> (k_q != '0 && k_q <= blk));

  assert_last_has_data_R8: assert property (@(posedge clk) disable iff (rst)
    !ind_n |-> dq_oe);

  assert_deselect_drops_R10: assert property (@(posedge clk) disable iff (rst)
    !chip_sel |=> (!vld_q && st_q == ST_IDLE));

endmodule

// File: tb/burst_read_seq_tb.sv
module burst_read_seq_tb;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = '0;
  logic [15:0]   cmd_arg = '0;
  logic          chip_sel = 1'b0;
  logic          addr_valid = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   dq_data;
  logic          dq_oe, ind_n;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_read_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .chip_sel(chip_sel), .addr_valid(addr_valid),
    .addr(addr), .dq_data(dq_data), .dq_oe(dq_oe), .ind_n(ind_n)
  );

  // {cfg, start address}
  localparam logic [31:0] VEC [6] = '{
    32'h8C01_0005, 32'h9002_0022, 32'h9403_001D,
    32'h8C02_0013, 32'h8001_0040, 32'h9C03_0000
  };

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
    logic [15:0] z;
    z = 16'(a);
    return {~z, z};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_cmd(input logic v, input logic [7:0] op, input logic [15:0] arg);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic async_read(input string req, input logic [AW-1:0] a);
    chip_sel = 1'b1; addr = a;
    @(negedge clk);
    check({req, " async oe"}, 32'(dq_oe), 32'd1);
    check({req, " async data (R1)"}, dq_data, exp_word(a));
    check({req, " async ind_n"}, 32'(ind_n), 32'd1);
  endtask

  task automatic run_burst(input logic [15:0] cfg, input logic [AW-1:0] s);
    int lat, n;
    logic [AW-1:0] a, m;
    lat = int'(cfg[13:10]);
    if (lat < 2) lat = 2;
    case (cfg[2:0])
      3'b001: n = 2;
      3'b010: n = 4;
      default: n = 8;
    endcase
    m = AW'(n - 1);
    wr_cmd(1'b1, 8'hD0, cfg);
    chip_sel = 1'b1; addr = s; addr_valid = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0;
    check("R5 oe low after strobe", 32'(dq_oe), 32'd0);
    for (int j = 1; j < lat; j++) begin
      @(negedge clk);
      check("R5 oe low during latency", 32'(dq_oe), 32'd0);
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      a = (s & ~m) | ((s + AW'(k)) & m);
      check("R6 oe during burst", 32'(dq_oe), 32'd1);
      check("R7 wrapped data", dq_data, exp_word(a));
      check("R8 ind_n", 32'(ind_n), (k == n - 1) ? 32'd0 : 32'd1);
    end
    @(negedge clk);
    check("R8 oe low after last", 32'(dq_oe), 32'd0);
    check("R8 ind_n high after last", 32'(ind_n), 32'd1);
  endtask

  initial begin
    // R4: reset state with chip_sel high
    chip_sel = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 oe in reset", 32'(dq_oe), 32'd0);
    check("R4 ind_n in reset", 32'(ind_n), 32'd1);
    rst = 1'b0;
    chip_sel = 1'b0;
    @(negedge clk);
    // R4/R2: default configuration is asynchronous
    async_read("R4 R2", 8'h31);
    async_read("R2", 8'h7A);
    async_read("R2", 8'hFF);
    // R3: foreign opcode and missing strobe leave config async
    wr_cmd(1'b1, 8'h55, 16'h8C01);
    async_read("R3 wrong opcode", 8'h12);
    wr_cmd(1'b0, 8'hD0, 16'h8C01);
    async_read("R3 no strobe", 8'h44);
    // table of bursts (R5..R8, latency clamp in entry 5)
    foreach (VEC[i]) run_burst(VEC[i][31:16], VEC[i][AW-1:0]);
    // R9: continuous burst wraps over array end, ind_n high
    wr_cmd(1'b1, 8'hD0, 16'h8C00);
    addr = 8'hFE; addr_valid = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R9 continuous oe", 32'(dq_oe), 32'd1);
      check("R9 continuous data", dq_data, exp_word(8'hFE + AW'(k)));
      check("R9 continuous ind_n", 32'(ind_n), 32'd1);
    end
    // R10: abort mid-burst
    chip_sel = 1'b0;
    #1;
    check("R10 oe drops at once", 32'(dq_oe), 32'd0);
    @(negedge clk);
    wr_cmd(1'b1, 8'hD0, 16'h8C03);
    chip_sel = 1'b1; addr = 8'h10; addr_valid = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 burst running", dq_data, exp_word(8'h10));
    @(negedge clk);
    check("R10 second word", dq_data, exp_word(8'h11));
    chip_sel = 1'b0;
    #1;
    check("R10 oe low on deselect", 32'(dq_oe), 32'd0);
    check("R10 ind_n high on deselect", 32'(ind_n), 32'd1);
    @(negedge clk);
    chip_sel = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check("R10 no resume", 32'(dq_oe), 32'd0);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

endmodule